// File: doc/BRIEF.md
# Debounced Pushbutton Single-Pulse Generator

This block turns a noisy mechanical pushbutton into one clean, single-cycle pulse on the system clock for each press. The raw button level (high while pressed) first passes through a two-stage synchronizer. A shift-register filter then debounces it. That filter shifts only on a sampling tick from a parameterized prescaler, so the debounce window is the tap count times the tick period. A one-bit state machine turns the rising edge of the debounced level into a pulse that lasts exactly one clock.

The filter holds its output level until every tap agrees. The edge machine has two named states. ST_ARMED means the button was last seen released. ST_HELD means it was last seen pressed. It has two transitions:
- arm-to-held: taken when the debounced level is high.
- held-to-arm: taken when the debounced level is low.

The next state always follows the debounced level. The pulse is high only in ST_ARMED while the level is high. Synchronous reset clears every stage to the released condition and forces the pulse low. The integrator sets TICK_DIV and TAPS so that their product covers the bounce time of the switch, typically around 10 ms.

Top module: `pushbutton_pulser`

## Requirements
- R1: The button input passes through two synchronizer flops before it reaches the filter. With the defaults (TICK_DIV=8, TAPS=4), a clean press gives its pulse no earlier than (TAPS-1)*TICK_DIV+4 rising edges after the press.
- R2: The filter samples on a tick that occurs once every TICK_DIV clocks, and the shift register changes only on a tick. A clean press gives its pulse no later than TAPS*TICK_DIV+3 rising edges after the press.
- R3: The debounced level rises only when all TAPS samples are high. A high bounce that lasts (TAPS-2)*TICK_DIV clocks or less produces no pulse.
- R4: The debounced level falls only when all TAPS samples are low. A release glitch that lasts (TAPS-2)*TICK_DIV clocks or less, while the button is held, produces no second pulse.
- R5: Every pulse on pulse_o is exactly one clock wide.
- R6: Holding the button for any length of time produces exactly one pulse.
- R7: Releasing the button produces no pulse.
- R8: pulse_o is low in every cycle where rst is high, including a cycle where a pulse would otherwise be emitted. Reset returns all state to the released condition.
- R9: If the button is held through reset, exactly one pulse follows, and only after a full debounce window measured from the release of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pb_in | input | 1 | Raw pushbutton level, high while pressed, asynchronous |
| pulse_o | output | 1 | One-cycle pulse per debounced press |

## Verification
Reset and pulse emission can fall in the same cycle. The bench holds the button until it sees pulse_o high at a falling clock edge, then raises rst in that same cycle. It checks that the pulse drops at once, before the next rising edge. The button stays held while reset is released. The bench then checks that no pulse appears before a full debounce window has passed, and that exactly one pulse appears inside the window bounds of R1 and R2.

// File: rtl/pbp_pkg.sv
package pbp_pkg;

    // Edge machine state: the last debounced level seen.
    typedef enum logic {
        ST_ARMED = 1'b0,
        ST_HELD  = 1'b1
    } pbp_state_t;

endpackage

// File: rtl/pbp_sync.sv
module pbp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/pbp_tick.sv
module pbp_tick #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    generate
        if (DIV > 1) begin : g_div
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign tick_o = (cnt_q == LAST);

            // R2: ticks never come on adjacent clocks when DIV exceeds one
            p_tick_spacing_r2: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o);
        end else begin : g_every
            assign tick_o = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/pbp_filter.sv
module pbp_filter #(
    parameter int TAPS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic sample_i,
    output logic level_o
);

    logic [TAPS-1:0] shreg_q;
    logic [TAPS-1:0] shreg_d;
    logic            level_q;
    logic            all_hi;
    logic            all_lo;

    generate
        if (TAPS > 1) begin : g_multi
            assign shreg_d = {shreg_q[TAPS-2:0], sample_i};
        end else begin : g_single
            assign shreg_d = sample_i;
        end
    endgenerate

    // Reset acts as a synchronous load of the released pattern.
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
        end else if (tick_i) begin
            shreg_q <= shreg_d;
        end
    end

    assign all_hi = &shreg_q;
    assign all_lo = ~|shreg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
        end else if (all_hi) begin
            level_q <= 1'b1;
        end else if (all_lo) begin
            level_q <= 1'b0;
        end
    end

    assign level_o = level_q;

    // R2: the taps move only when a tick was present
    p_shift_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(shreg_q));

    // R3: a rise of the level needs unanimous high taps
    p_rise_agree_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(level_q) |-> $past(all_hi));

    // R4: a fall of the level needs unanimous low taps
    p_fall_agree_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(level_q) |-> $past(all_lo));

endmodule

// File: rtl/pbp_edge_fsm.sv
module pbp_edge_fsm
    import pbp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic pulse_o
);

    pbp_state_t state_q;
    pbp_state_t state_d;

    // Next state simply tracks the debounced level.
    always_comb begin
        state_d = level_i ? ST_HELD : ST_ARMED;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decoding, gated by the level and by reset.
    always_comb begin
        pulse_o = 1'b0;
        unique case (state_q)
            ST_ARMED: pulse_o = level_i & ~rst;
            ST_HELD:  pulse_o = 1'b0;
        endcase
    end

    // R5: a pulse never lasts two clocks
    p_single_cycle_r5: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o);

    // R8: no pulse while reset is applied
    p_quiet_in_reset_r8: assert property (@(posedge clk)
        rst |-> !pulse_o);

    // R6: after a pulse, the machine stays silent while the level stays high
    p_no_repeat_r6: assert property (@(posedge clk) disable iff (rst)
        (pulse_o && level_i) |=> (!pulse_o));

endmodule

// File: rtl/pushbutton_pulser.sv
module pushbutton_pulser #(
    parameter int TICK_DIV    = 8,
    parameter int TAPS        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pb_in,
    output logic pulse_o
);

    logic pb_sync;
    logic tick;
    logic level;

    pbp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (pb_in),
        .sync_o  (pb_sync)
    );

    pbp_tick #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    pbp_filter #(.TAPS(TAPS)) u_filter (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick),
        .sample_i (pb_sync),
        .level_o  (level)
    );

    pbp_edge_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .level_i (level),
        .pulse_o (pulse_o)
    );

endmodule

// File: tb/tb_pushbutton_pulser.sv
module tb_pushbutton_pulser;

    localparam int DIV  = 8;
    localparam int TAPS = 4;
    localparam int LAT_MIN = (TAPS-1)*DIV + 4;
    localparam int LAT_MAX = TAPS*DIV + 3;
    localparam int BOUNCE  = (TAPS-2)*DIV;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pb_in = 1'b0;
    logic pulse_o;

    int total = 0;
    int bad = 0;
    int pcount = 0;
    int wide = 0;
    logic prev_pulse = 1'b0;
    bit done = 0;

    pushbutton_pulser #(.TICK_DIV(DIV), .TAPS(TAPS), .SYNC_STAGES(2)) dut (
        .clk     (clk),
        .rst     (rst),
        .pb_in   (pb_in),
        .pulse_o (pulse_o)
    );

    always #2 clk = ~clk;

    // Pulse monitor at the falling edge.
    always @(negedge clk) begin
        if (pulse_o === 1'b1) pcount++;
        if (pulse_o === 1'b1 && prev_pulse === 1'b1) wide++;
        prev_pulse = pulse_o;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_state();
        cycles(3);
        check(pulse_o === 1'b0, "R8 pulse low in reset", int'(pulse_o), 0);
        rst = 1'b0;
        cycles(60);
        check(pcount == 0, "R8 idle after reset", pcount, 0);
    endtask

    task automatic t_press_latency();
        int lat = -1;
        int base = pcount;
        pb_in = 1'b1;
        for (int k = 1; k <= 60; k++) begin
            @(negedge clk);
            if (pulse_o === 1'b1 && lat < 0) lat = k;
        end
        check(lat >= LAT_MIN, "R1 pulse not earlier than min latency", lat, LAT_MIN);
        check(lat >= 0 && lat <= LAT_MAX, "R2 pulse within max latency", lat, LAT_MAX);
        check(pcount - base == 1, "R5 one pulse for press", pcount - base, 1);
    endtask

    task automatic t_long_hold();
        int base = pcount;
        cycles(800);
        check(pcount == base, "R6 no extra pulse while held", pcount - base, 0);
    endtask

    task automatic t_glitch_in_hold();
        int base = pcount;
        pb_in = 1'b0;
        cycles(BOUNCE);
        pb_in = 1'b1;
        cycles(100);
        check(pcount == base, "R4 short release glitch ignored", pcount - base, 0);
    endtask

    task automatic t_release();
        int base = pcount;
        pb_in = 1'b0;
        cycles(100);
        check(pcount == base, "R7 no pulse on release", pcount - base, 0);
    endtask

    task automatic t_bounce();
        int base = pcount;
        for (int b = 0; b < 3; b++) begin
            pb_in = 1'b1;
            cycles(BOUNCE);
            pb_in = 1'b0;
            cycles(BOUNCE + 3);
        end
        cycles(80);
        check(pcount == base, "R3 short high bounces ignored", pcount - base, 0);
    endtask

    task automatic t_second_press();
        int base = pcount;
        pb_in = 1'b1;
        cycles(LAT_MAX + 20);
        check(pcount - base == 1, "R6 second press gives one pulse", pcount - base, 1);
        pb_in = 1'b0;
        cycles(80);
        check(pcount - base == 1, "R7 second release silent", pcount - base, 1);
    endtask

    task automatic t_reset_collision();
        int base;
        bit seen = 0;
        pb_in = 1'b1;
        for (int k = 0; k < LAT_MAX + 10; k++) begin
            @(negedge clk);
            if (pulse_o === 1'b1 && !seen) begin
                seen = 1;
                rst = 1'b1;
                #1;
                check(pulse_o === 1'b0, "R8 reset masks pulse same cycle", int'(pulse_o), 0);
                break;
            end
        end
        check(seen, "R8 pulse reached before collision", int'(seen), 1);
        cycles(4);
        rst = 1'b0;
        base = pcount;
        cycles(LAT_MIN - 1);
        check(pcount == base, "R9 no pulse before window after reset", pcount - base, 0);
        cycles(LAT_MAX - LAT_MIN + 10);
        check(pcount - base == 1, "R9 one pulse after window with held button", pcount - base, 1);
        pb_in = 1'b0;
        cycles(80);
    endtask

    initial begin
        t_reset_state();
        t_press_latency();
        t_long_hold();
        t_glitch_in_hold();
        t_release();
        t_bounce();
        t_second_press();
        t_reset_collision();
        check(wide == 0, "R5 no pulse wider than one cycle", wide, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule